// File: doc/BRIEF.md
# Ring-Cascaded Deep FIFO

This block builds one deep first-in first-out buffer of 9-bit words from a number of identical buffer slices. No central address decoder is involved. The slices sit in a ring. Each slice keeps its own storage, its own read and write pointers and its own occupancy counter. Two ownership tokens travel around the ring:

- The write token marks the single slice that takes incoming words.
- The read token marks the single slice that supplies outgoing words.

A slice passes a token forward with a one-cycle pulse on its ring output. It does so at the moment it fills, or drains, its last storage location. The write pulse and the read pulse are separate signals. The slice downstream therefore always knows which token it is receiving.

The write strobe, the read strobe and the input word go to every slice. Only the token holder acts on each strobe. A per-slice start strap, active low, chooses which slice owns both tokens when reset is released. Composite empty and full flags come from the token holders:

- The buffer is empty when the read-token slice has no data.
- It is full when the write-token slice has no free location.

A read that is accepted returns its word one clock later with a valid pulse. Only the slice that served the read drives the output word. At all other times the output word is zero.

Top module: `fifo_ring_cascade`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `empty` is 1, `full` is 0, `rd_valid` is 0 and `rd_data` is zero.
- R2: Words are read out in exactly the order they were accepted, across slice boundaries, for a total capacity of NUM_SLICES*SLICE_DEPTH words.
- R3: `full` is 1 exactly when NUM_SLICES*SLICE_DEPTH words are held. A write strobe while full is ignored, and the dropped word never appears at the output.
- R4: A read strobe while `empty` is 1 is ignored. No `rd_valid` pulse follows it, and the stored sequence is unchanged.
- R5: An accepted read raises `rd_valid` for one cycle on the next clock edge, with the word on `rd_data`. When `rd_valid` is 0, `rd_data` is zero. At most one slice drives a word in any cycle.
- R6: The slice whose `first_load_n` bit is 0 at reset release takes the first word and serves the first read. R2 holds whichever slice is chosen. Exactly one bit of `first_load_n` must be 0.
- R7: Exactly one slice holds the write token and exactly one holds the read token at all times. Each token moves to the next slice (index+1, with the last slice wrapping to slice 0) when its holder writes, or reads, its last location. A stream much longer than the capacity therefore stays in order.
- R8: A read and a write in the same cycle both take effect when the buffer is neither empty nor full. The occupancy stays unchanged.
- R9: `empty` and `full` reflect the occupancy one edge after each accepted access. `empty` falls one edge after a write into an empty buffer. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| first_load_n | input | NUM_SLICES | Start strap, active low, one-cold; selects the slice that holds both tokens after reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | WORD_W | Word returned by the read accepted on the previous edge; zero otherwise |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| empty | output | 1 | Composite empty: the read-token slice holds no data |
| full | output | 1 | Composite full: the write-token slice has no free location |

## Verification
The assertions rely on two conditions on the inputs. First, `first_load_n` carries exactly one zero and stays steady through reset and the first clock after it. Second, the strobes change only away from the rising edge. The bench meets both conditions:

- It changes the strap only while reset is held, and always to a one-cold value.
- It drives every input half a period away from the edge.

Under these conditions the token one-hot properties, and the flag properties that build on them, hold from reset release. Strobes while full and while empty are applied on purpose, because the block defines how it handles them.

// File: rtl/fring_pkg.sv
package fring_pkg;

  // Token hand-off pulses carried from one slice to the next on the ring.
  typedef struct packed {
    logic wr_pass;
    logic rd_pass;
  } ring_pulse_t;

endpackage

// File: rtl/fring_mem.sv
module fring_mem #(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] store_q [DEPTH];

  // Storage array: no reset, written only on an accepted write.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_data;
    end
  end

  // Registered read port, loaded only on an accepted read.
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_word <= store_q[rd_addr];
    end
  end

endmodule

// File: rtl/fring_slice.sv
module fring_slice
  import fring_pkg::*;
#(
  parameter int WORD_W = 9,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              first_load_n,
  input  ring_pulse_t       ring_in,
  output ring_pulse_t       ring_out,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_req,
  output logic              own_wr,
  output logic              own_rd,
  output logic              is_full,
  output logic              has_data,
  output logic              out_vld,
  output logic [WORD_W-1:0] out_word
);

  localparam logic [AW-1:0] LAST_LOC = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP_CNT  = CW'(DEPTH);

  logic          started_q;
  logic          wtok_q, wtok_d;
  logic          rtok_q, rtok_d;
  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q,  cnt_d;
  logic          vld_q;
  logic          wr_do, rd_do;
  logic          w_last, r_last;
  logic [WORD_W-1:0] mem_word;

  // Before the first edge after reset the strap decides the token owner.
  assign own_wr   = started_q ? wtok_q : ~first_load_n;
  assign own_rd   = started_q ? rtok_q : ~first_load_n;
  assign is_full  = (cnt_q == CAP_CNT);
  assign has_data = (cnt_q != '0);

  assign wr_do  = wr_req & own_wr & ~is_full;
  assign rd_do  = rd_req & own_rd & has_data;
  assign w_last = (wptr_q == LAST_LOC);
  assign r_last = (rptr_q == LAST_LOC);

  always_comb begin
    ring_out.wr_pass = wr_do & w_last;
    ring_out.rd_pass = rd_do & r_last;

    wtok_d = (own_wr & ~ring_out.wr_pass) | ring_in.wr_pass;
    rtok_d = (own_rd & ~ring_out.rd_pass) | ring_in.rd_pass;

    wptr_d = wptr_q;
    if (wr_do) begin
      wptr_d = w_last ? '0 : wptr_q + AW'(1);
    end

    rptr_d = rptr_q;
    if (rd_do) begin
      rptr_d = r_last ? '0 : rptr_q + AW'(1);
    end

    cnt_d = cnt_q + CW'(wr_do) - CW'(rd_do);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started_q <= 1'b0;
      wtok_q    <= 1'b0;
      rtok_q    <= 1'b0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      cnt_q     <= '0;
      vld_q     <= 1'b0;
    end else begin
      started_q <= 1'b1;
      wtok_q    <= wtok_d;
      rtok_q    <= rtok_d;
      if (wr_do) begin
        wptr_q <= wptr_d;
      end
      if (rd_do) begin
        rptr_q <= rptr_d;
      end
      if (wr_do != rd_do) begin
        cnt_q <= cnt_d;
      end
      vld_q <= rd_do;
    end
  end

  fring_mem #(
    .WORD_W (WORD_W),
    .DEPTH  (DEPTH)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_do),
    .wr_addr (wptr_q),
    .wr_data (wr_word),
    .rd_en   (rd_do),
    .rd_addr (rptr_q),
    .rd_word (mem_word)
  );

  // A slice that did not serve the last read presents an all-zero word.
  assign out_vld  = vld_q;
  assign out_word = vld_q ? mem_word : '0;

endmodule

// File: rtl/fring_rdmux.sv
module fring_rdmux #(
  parameter int NUM_SLICES = 4,
  parameter int WORD_W     = 9
) (
  input  logic [NUM_SLICES-1:0]             slice_vld,
  input  logic [NUM_SLICES-1:0][WORD_W-1:0] slice_word,
  output logic                              rd_valid,
  output logic [WORD_W-1:0]                 rd_data
);

  // The words arrive already gated to zero, so an OR tree selects the server.
  always_comb begin
    rd_valid = 1'b0;
    rd_data  = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      rd_valid = rd_valid | slice_vld[i];
      rd_data  = rd_data  | slice_word[i];
    end
  end

endmodule

// File: rtl/fifo_ring_cascade.sv
module fifo_ring_cascade
  import fring_pkg::*;
#(
  parameter int NUM_SLICES  = 4,
  parameter int SLICE_DEPTH = 8,
  parameter int WORD_W      = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] first_load_n,
  input  logic                  wr_en,
  input  logic [WORD_W-1:0]     wr_data,
  input  logic                  rd_en,
  output logic [WORD_W-1:0]     rd_data,
  output logic                  rd_valid,
  output logic                  empty,
  output logic                  full
);

  ring_pulse_t                       ring_vec [NUM_SLICES];
  logic [NUM_SLICES-1:0]             own_wr_vec;
  logic [NUM_SLICES-1:0]             own_rd_vec;
  logic [NUM_SLICES-1:0]             full_vec;
  logic [NUM_SLICES-1:0]             data_vec;
  logic [NUM_SLICES-1:0]             slice_rv;
  logic [NUM_SLICES-1:0][WORD_W-1:0] slice_word;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    localparam int PREV = (i == 0) ? NUM_SLICES - 1 : i - 1;

    fring_slice #(
      .WORD_W (WORD_W),
      .DEPTH  (SLICE_DEPTH)
    ) u_slice (
      .clk          (clk),
      .rst_n        (rst_n),
      .first_load_n (first_load_n[i]),
      .ring_in      (ring_vec[PREV]),
      .ring_out     (ring_vec[i]),
      .wr_req       (wr_en),
      .wr_word      (wr_data),
      .rd_req       (rd_en),
      .own_wr       (own_wr_vec[i]),
      .own_rd       (own_rd_vec[i]),
      .is_full      (full_vec[i]),
      .has_data     (data_vec[i]),
      .out_vld      (slice_rv[i]),
      .out_word     (slice_word[i])
    );
  end

  // Composite flags come from the token holders only.
  assign empty = ~|(own_rd_vec & data_vec);
  assign full  =  |(own_wr_vec & full_vec);

  fring_rdmux #(
    .NUM_SLICES (NUM_SLICES),
    .WORD_W     (WORD_W)
  ) u_rdmux (
    .slice_vld  (slice_rv),
    .slice_word (slice_word),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/fring_cascade_chk.sv
module fring_cascade_chk #(
  parameter int NUM_SLICES = 4,
  parameter int WORD_W     = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic                  empty,
  input logic                  full,
  input logic                  rd_valid,
  input logic [WORD_W-1:0]     rd_data,
  input logic [NUM_SLICES-1:0] own_wr_vec,
  input logic [NUM_SLICES-1:0] own_rd_vec,
  input logic [NUM_SLICES-1:0] slice_rv
);

  assert_one_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(own_wr_vec));

  assert_one_reader_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(own_rd_vec));

  assert_single_server_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slice_rv));

  assert_quiet_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en) |=> full);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> !rd_valid);

  assert_flags_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));

  assert_fill_from_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_en) |=> !empty);

endmodule

bind fifo_ring_cascade fring_cascade_chk #(
  .NUM_SLICES (NUM_SLICES),
  .WORD_W     (WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .empty      (empty),
  .full       (full),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .own_wr_vec (own_wr_vec),
  .own_rd_vec (own_rd_vec),
  .slice_rv   (slice_rv)
);

// File: tb/fifo_ring_cascade_tb.sv
module fifo_ring_cascade_tb;

  localparam int N   = 4;
  localparam int D   = 8;
  localparam int W   = 9;
  localparam int CAP = N * D;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] first_load_n;
  logic         wr_en, rd_en;
  logic [W-1:0] wr_data;
  logic [W-1:0] rd_data;
  logic         rd_valid, empty, full;

  always #10 clk = ~clk;

  fifo_ring_cascade #(
    .NUM_SLICES  (N),
    .SLICE_DEPTH (D),
    .WORD_W      (W)
  ) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .first_load_n (first_load_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .empty        (empty),
    .full         (full)
  );

  int           total = 0;
  int           bad   = 0;
  logic [W-1:0] exp_q [$];
  int           model_cnt = 0;
  bit           exp_rv = 1'b0;
  logic [W-1:0] exp_word = '0;
  bit           mon_on = 1'b0;
  string        cur_req = "R1";
  logic [15:0]  lfsr = 16'hACE1;

  task automatic check(bit ok, string req, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Driver: drives one cycle and records what the scoreboard expects.
  task automatic step(bit w, logic [W-1:0] d, bit r);
    bit w_ok, r_ok;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r;
    w_ok = w && (model_cnt < CAP);
    r_ok = r && (model_cnt > 0);
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
    exp_rv = r_ok;
    if (r_ok) exp_word = exp_q.pop_front();
    if (w_ok) exp_q.push_back(d);
    model_cnt = exp_q.size();
  endtask

  // Monitor: compares outputs against the scoreboard away from the edge.
  always @(negedge clk) begin
    if (mon_on) begin
      check(rd_valid == exp_rv, "R5", {cur_req, " rd_valid"}, rd_valid, exp_rv);
      if (exp_rv && rd_valid)
        check(rd_data == exp_word, "R2", {cur_req, " rd_data order"}, rd_data, exp_word);
      if (!rd_valid)
        check(rd_data == '0, "R5", {cur_req, " idle rd_data"}, rd_data, 0);
      check(empty == (model_cnt == 0), "R9", {cur_req, " empty"}, empty, model_cnt == 0);
      check(full == (model_cnt == CAP), "R3", {cur_req, " full"}, full, model_cnt == CAP);
    end
  end

  task automatic do_reset(logic [N-1:0] strap);
    mon_on = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; first_load_n = strap;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(empty == 1'b1 && full == 1'b0 && rd_valid == 1'b0, "R1", "flags in reset",
          {empty, full, rd_valid}, 3'b100);
    rst_n = 1'b1;
    exp_q.delete(); model_cnt = 0; exp_rv = 1'b0;
    #1;
    check(empty == 1'b1 && full == 1'b0 && rd_valid == 1'b0 && rd_data == '0, "R1",
          "flags after release", {empty, full, rd_valid}, 3'b100);
    mon_on = 1'b1;
  endtask

  task automatic fill_drain(int base);
    for (int k = 0; k < CAP; k++) step(1'b1, W'(base + k), 1'b0);
    check(full == 1'b1, "R3", "full at capacity", full, 1);
    for (int k = 0; k < 3; k++) step(1'b1, 9'h1AA, 1'b0);
    check(model_cnt == CAP, "R3", "writes while full dropped", model_cnt, CAP);
    for (int k = 0; k < CAP; k++) step(1'b0, '0, 1'b1);
    check(empty == 1'b1, "R2", "empty after full drain", empty, 1);
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic mixed(int cycles);
    for (int k = 0; k < cycles; k++) begin
      lfsr = lfsr_next(lfsr);
      step(lfsr[0] | lfsr[5], W'(lfsr[15:7]), lfsr[3] | lfsr[9]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; first_load_n = '1; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;

    // R1: reset with slice 0 as the start slice.
    cur_req = "R1";
    do_reset(~N'(1));

    // R4: reads on an empty buffer are ignored.
    cur_req = "R4";
    for (int k = 0; k < 3; k++) step(1'b0, '0, 1'b1);
    check(rd_valid == 1'b0 && empty == 1'b1, "R4", "empty reads ignored", rd_valid, 0);

    // R9: one write clears empty on the next edge.
    cur_req = "R9";
    step(1'b1, 9'h055, 1'b0);
    check(empty == 1'b0, "R9", "empty drops after write", empty, 0);
    step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check(empty == 1'b1, "R9", "empty again after drain", empty, 1);

    // R3: fill past capacity across all slices, then drain in order.
    cur_req = "R3";
    fill_drain(9'h010);

    // R8: simultaneous read and write at mid occupancy.
    cur_req = "R8";
    for (int k = 0; k < 10; k++) step(1'b1, W'(9'h100 + k), 1'b0);
    for (int k = 0; k < 80; k++) step(1'b1, W'(9'h0C0 + k), 1'b1);
    check(model_cnt == 10, "R8", "occupancy steady under read+write", model_cnt, 10);

    // R7: long traffic wraps both tokens around the ring many times.
    cur_req = "R7";
    mixed(3000);
    while (model_cnt > 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check(empty == 1'b1, "R7", "empty after long traffic", empty, 1);

    // R6: start from the last slice instead.
    cur_req = "R6";
    do_reset(~(N'(1) << (N - 1)));
    fill_drain(9'h140);
    mixed(1500);
    while (model_cnt > 0) step(1'b0, '0, 1'b1);
    step(1'b0, '0, 1'b0);
    check(exp_q.size() == 0 && empty == 1'b1, "R6", "order with other start slice",
          exp_q.size(), 0);

    mon_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule